// File: doc/BRIEF.md
# Multi-Line Serial Transmit Scanner

This block is the transmit half of a serial multiplexer that serves several asynchronous lines through one shared data register. Software turns on the lines it wants to send on in a line-enable register and sets a master scan bit. A round-robin scanner then looks for an enabled line whose one-character holding register is empty. When it finds one, it raises a ready flag and shows that line's number in the control/status register. The host answers by writing one character to the data register. The character goes to the reported line, and the scanner moves on.

Each line has a one-entry holding register in front of a shift register. When the shifter is idle, the held character moves into it and is sent as a frame: one start bit, the data bits least significant first, and one stop bit. A clear bit in the control/status register returns the whole block to a quiet state. The clear takes a fixed number of cycles, and the clear bit reads back as 1 until it is done. A transmit interrupt request follows the ready flag, gated by an interrupt-enable bit.

Top module: `mux_tx_scanner`

## Requirements
- R1: After the synchronous reset, the status word and the line-enable readback are 0, the interrupt request is low and every serial output idles high.
- R2: While the scan-enable bit (status bit 5) is 0, the ready flag (status bit 15) stays 0. Clearing scan-enable while ready is set withdraws ready at the next edge.
- R3: When scanning is on and some line is enabled (line-enable register bit i for line i) and has an empty holding register, ready is set at the next edge. The chosen line number appears in status bits 9:8.
- R4: The search for the next line starts at the line just after the last line served and wraps around. The last line served therefore has the lowest priority. After a reset or a clear, line 0 is searched first.
- R5: A write to the data register (address 2) while ready is set loads the character into the reported line and drops ready at that edge. A data write while ready is clear has no effect.
- R6: Each line holds one character. A line whose holding register is full is never reported.
- R7: A reported line is always enabled. If the host clears the enable bit of the reported line, ready drops at that edge, and another enabled, empty line is reported at the following edge.
- R8: The interrupt request is high exactly when both ready and the interrupt-enable bit (status bit 14) are set.
- R9: Writing 1 to status bit 4 starts a clear. Bit 4 then reads 1 for RST_CYCLES cycles and afterwards reads 0. The clear zeroes the line enables, scan-enable, interrupt-enable, ready and all holding registers and shifters. Register writes made while the clear is running are ignored.
- R10: Each serial output idles high. A held character starts its frame at the edge after the shifter is found idle. The frame is a low start bit, DATA_W data bits least significant first, and a high stop bit, with each bit lasting BIT_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select: 0 status/control, 1 line enables, 2 transmit data |
| host_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Status word: 15 ready, 14 interrupt enable, 9:8 line, 5 scan enable, 4 clear busy |
| line_en_rdata | output | 16 | Line-enable register readback |
| tx_irq | output | 1 | Transmit interrupt request |
| ser_out | output | NLINES | Serial data output for each line |

## Verification
The hardest case to reach is the one where every enabled line has a full holding register while its shifter is still sending the previous character. Only then does ready stay low with scanning on, and only then does the round-robin pointer have to wait for a line to free up. The bench reaches this case by answering eight ready reports back to back, faster than one frame lasts, so that each line holds a second character behind the one being shifted. It then pokes a data write into the gap. A second hard case is withdrawing the enable of the reported line: the bench first drains all lines so that the report is stable, and only then rewrites the enable register.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int MAX_LINES = 16;
    localparam int IDX_W     = 4;

    // Control/status bit positions
    localparam int CSR_CLR      = 4;
    localparam int CSR_SCAN     = 5;
    localparam int CSR_LINE_LSB = 8;
    localparam int CSR_TIE      = 14;
    localparam int CSR_RDY      = 15;

    typedef enum logic [1:0] {
        REG_CSR  = 2'd0,
        REG_LEN  = 2'd1,
        REG_TXD  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Round-robin search: first candidate after 'last', wrapping modulo n.
    function automatic pick_t rr_pick(input logic [MAX_LINES-1:0] cand,
                                      input int n,
                                      input logic [IDX_W-1:0] last);
        pick_t r;
        int    idx;
        r.found = 1'b0;
        r.idx   = '0;
        for (int k = 1; k <= MAX_LINES; k++) begin
            idx = (int'(last) + k) % n;
            if (k <= n && !r.found && cand[idx]) begin
                r.found = 1'b1;
                r.idx   = IDX_W'(idx);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/txs_ctrl.sv
module txs_ctrl
    import txs_pkg::*;
#(
    parameter int NLINES     = 4,
    parameter int RST_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic              scan_q,
    output logic              tie_q,
    output logic [NLINES-1:0] en_q,
    output logic              busy_q,
    output logic              scan_d,
    output logic [NLINES-1:0] en_d,
    output logic              wipe,
    output logic              txd_wr
);

    localparam int RC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    reg_sel_e        sel;
    logic            sel_csr;
    logic            sel_len;
    logic            sel_txd;
    logic            clr_start;
    logic            tie_d;
    logic [RC_W-1:0] cnt_q;
    logic            unused_ok;

    assign sel     = reg_sel_e'(host_addr);
    assign sel_csr = host_we && (sel == REG_CSR);
    assign sel_len = host_we && (sel == REG_LEN);
    assign sel_txd = host_we && (sel == REG_TXD);

    assign clr_start = !busy_q && sel_csr && host_wdata[CSR_CLR];
    assign wipe      = busy_q || clr_start;
    assign txd_wr    = !wipe && sel_txd;

    assign unused_ok = ^host_wdata;

    always_comb begin
        scan_d = scan_q;
        tie_d  = tie_q;
        en_d   = en_q;
        if (wipe) begin
            scan_d = 1'b0;
            tie_d  = 1'b0;
            en_d   = '0;
        end else begin
            if (sel_csr) begin
                scan_d = host_wdata[CSR_SCAN];
                tie_d  = host_wdata[CSR_TIE];
            end
            if (sel_len) begin
                en_d = host_wdata[NLINES-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= 1'b0;
            tie_q  <= 1'b0;
            en_q   <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            scan_q <= scan_d;
            tie_q  <= tie_d;
            en_q   <= en_d;
            if (clr_start) begin
                busy_q <= 1'b1;
                cnt_q  <= RC_W'(RST_CYCLES - 1);
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/txs_scanner.sv
module txs_scanner
    import txs_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int LINE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic [NLINES-1:0] en_d,
    input  logic              scan_d,
    input  logic [NLINES-1:0] hold_full,
    input  logic              txd_wr,
    output logic              ready_q,
    output logic [LINE_W-1:0] line_q,
    output logic [NLINES-1:0] load_vec
);

    logic [IDX_W-1:0]     last_q;
    logic [NLINES-1:0]    cand;
    pick_t                pick;
    logic                 accept;
    logic                 cur_en;
    logic                 unused_ok;

    assign cand   = en_d & ~hold_full;
    assign pick   = rr_pick(MAX_LINES'(cand), NLINES, last_q);
    assign accept = ready_q && txd_wr;
    assign cur_en = en_d[line_q];

    assign unused_ok = ^pick.idx;

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_load
            assign load_vec[i] = accept && (line_q == LINE_W'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            ready_q <= 1'b0;
            line_q  <= '0;
            last_q  <= IDX_W'(NLINES - 1);
        end else if (ready_q) begin
            if (accept) begin
                last_q <= IDX_W'(line_q);
            end
            if (accept || !cur_en || !scan_d) begin
                ready_q <= 1'b0;
            end
        end else if (scan_d && pick.found) begin
            ready_q <= 1'b1;
            line_q  <= pick.idx[LINE_W-1:0];
        end
    end

endmodule

// File: rtl/txs_line.sv
module txs_line #(
    parameter int DATA_W     = 8,
    parameter int BIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              hold_full,
    output logic              ser
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int BITS_W  = $clog2(FRAME_W + 1);
    localparam int DIV_W   = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;

    logic [DATA_W-1:0]  hold_q;
    logic [FRAME_W-1:0] shift_q;
    logic               busy_q;
    logic [BITS_W-1:0]  bits_q;
    logic [DIV_W-1:0]   div_q;
    logic               take;

    assign take = !busy_q && hold_full;
    assign ser  = busy_q ? shift_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            shift_q   <= '1;
            busy_q    <= 1'b0;
            bits_q    <= '0;
            div_q     <= '0;
        end else begin
            if (load) begin
                hold_q    <= data;
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end

            if (take) begin
                shift_q <= {1'b1, hold_q, 1'b0};
                busy_q  <= 1'b1;
                bits_q  <= BITS_W'(FRAME_W);
                div_q   <= DIV_W'(BIT_CYCLES - 1);
            end else if (busy_q) begin
                if (div_q == '0) begin
                    div_q   <= DIV_W'(BIT_CYCLES - 1);
                    shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                    bits_q  <= bits_q - 1'b1;
                    if (bits_q == BITS_W'(1)) begin
                        busy_q <= 1'b0;
                    end
                end else begin
                    div_q <= div_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mux_tx_scanner.sv
module mux_tx_scanner
    import txs_pkg::*;
#(
    parameter int NLINES     = 4,
    parameter int DATA_W     = 8,
    parameter int BIT_CYCLES = 4,
    parameter int RST_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       csr_rdata,
    output logic [15:0]       line_en_rdata,
    output logic              tx_irq,
    output logic [NLINES-1:0] ser_out
);

    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic              scan_q;
    logic              tie_q;
    logic [NLINES-1:0] en_q;
    logic              busy_q;
    logic              scan_d;
    logic [NLINES-1:0] en_d;
    logic              wipe;
    logic              txd_wr;
    logic              ready_q;
    logic [LINE_W-1:0] line_q;
    logic [NLINES-1:0] load_vec;
    logic [NLINES-1:0] hold_full;

    txs_ctrl #(
        .NLINES     (NLINES),
        .RST_CYCLES (RST_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .scan_q     (scan_q),
        .tie_q      (tie_q),
        .en_q       (en_q),
        .busy_q     (busy_q),
        .scan_d     (scan_d),
        .en_d       (en_d),
        .wipe       (wipe),
        .txd_wr     (txd_wr)
    );

    txs_scanner #(
        .NLINES (NLINES),
        .LINE_W (LINE_W)
    ) u_scan (
        .clk       (clk),
        .rst       (rst),
        .wipe      (wipe),
        .en_d      (en_d),
        .scan_d    (scan_d),
        .hold_full (hold_full),
        .txd_wr    (txd_wr),
        .ready_q   (ready_q),
        .line_q    (line_q),
        .load_vec  (load_vec)
    );

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            txs_line #(
                .DATA_W     (DATA_W),
                .BIT_CYCLES (BIT_CYCLES)
            ) u_line (
                .clk       (clk),
                .rst       (rst),
                .wipe      (wipe),
                .load      (load_vec[i]),
                .data      (host_wdata[DATA_W-1:0]),
                .hold_full (hold_full[i]),
                .ser       (ser_out[i])
            );
        end
    endgenerate

    always_comb begin
        csr_rdata                           = '0;
        csr_rdata[CSR_RDY]                  = ready_q;
        csr_rdata[CSR_TIE]                  = tie_q;
        csr_rdata[CSR_LINE_LSB +: LINE_W]   = line_q;
        csr_rdata[CSR_SCAN]                 = scan_q;
        csr_rdata[CSR_CLR]                  = busy_q;
    end

    assign line_en_rdata = 16'(en_q);
    assign tx_irq        = ready_q && tie_q;

endmodule

// File: rtl/mux_tx_scanner_chk.sv
module mux_tx_scanner_chk #(
    parameter int NLINES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       csr,
    input logic [15:0]       len,
    input logic              irq,
    input logic              we,
    input logic [1:0]        addr,
    input logic [NLINES-1:0] hold_full
);

    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic [LINE_W-1:0] rep_line;
    assign rep_line = csr[8 +: LINE_W];

    a_r2_scan_gates_ready: assert property (@(posedge clk) disable iff (rst)
        csr[15] |-> csr[5]);

    a_r7_reported_enabled: assert property (@(posedge clk) disable iff (rst)
        csr[15] |-> len[rep_line]);

    a_r6_reported_empty: assert property (@(posedge clk) disable iff (rst)
        csr[15] |-> !hold_full[rep_line]);

    a_r5_accept_drops: assert property (@(posedge clk) disable iff (rst)
        (csr[15] && !csr[4] && we && addr == 2'd2) |=> !csr[15]);

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq == (csr[15] && csr[14]));

    a_r9_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        csr[4] |-> (len == 16'd0 && !csr[15] && !csr[14] && !csr[5]));

endmodule

bind mux_tx_scanner mux_tx_scanner_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .csr       (csr_rdata),
    .len       (line_en_rdata),
    .irq       (tx_irq),
    .we        (host_we),
    .addr      (host_addr),
    .hold_full (hold_full)
);

// File: tb/mux_tx_scanner_bench.sv
module mux_tx_scanner_bench;

    localparam int NL  = 4;
    localparam int DW  = 8;
    localparam int BC  = 4;
    localparam int RC  = 6;
    localparam int WDOG = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] csr_rdata;
    logic [15:0] line_en_rdata;
    logic        tx_irq;
    logic [NL-1:0] ser_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mux_tx_scanner #(
        .NLINES(NL), .DATA_W(DW), .BIT_CYCLES(BC), .RST_CYCLES(RC)
    ) u_mux_tx_scanner (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .csr_rdata(csr_rdata),
        .line_en_rdata(line_en_rdata), .tx_irq(tx_irq), .ser_out(ser_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_en, m_scan, m_tie, m_ready, m_line, m_last, m_busy, m_cnt;
    int m_hv [NL];
    int m_hd [NL];
    int m_sb [NL];
    int m_sh [NL];
    int m_bits [NL];
    int m_div [NL];

    task automatic m_wipe();
        m_en = 0; m_scan = 0; m_tie = 0; m_ready = 0; m_line = 0; m_last = NL - 1;
        for (int i = 0; i < NL; i++) begin
            m_hv[i] = 0; m_hd[i] = 0; m_sb[i] = 0; m_sh[i] = 0; m_bits[i] = 0; m_div[i] = 0;
        end
    endtask

    always @(posedge clk) begin
        int ne, ns, nt, found, idx;
        bit dw;
        int old_hv [NL];
        if (rst) begin
            m_wipe(); m_busy = 0; m_cnt = 0;
        end else if (m_busy != 0) begin
            m_wipe();
            if (m_cnt == 0) m_busy = 0; else m_cnt--;
        end else if (host_we && host_addr == 2'd0 && host_wdata[4]) begin
            m_wipe(); m_busy = 1; m_cnt = RC - 1;
        end else begin
            ne = m_en; ns = m_scan; nt = m_tie;
            if (host_we && host_addr == 2'd0) begin
                ns = host_wdata[5]; nt = host_wdata[14];
            end
            if (host_we && host_addr == 2'd1) ne = int'(host_wdata) & ((1 << NL) - 1);
            dw = host_we && host_addr == 2'd2;
            for (int i = 0; i < NL; i++) old_hv[i] = m_hv[i];
            for (int i = 0; i < NL; i++) begin
                if (m_sb[i] != 0) begin
                    if (m_div[i] == 0) begin
                        m_div[i] = BC - 1;
                        m_sh[i] = (m_sh[i] >> 1) | (1 << (DW + 1));
                        m_bits[i]--;
                        if (m_bits[i] == 0) m_sb[i] = 0;
                    end else m_div[i]--;
                end else if (old_hv[i] != 0) begin
                    m_sh[i] = (1 << (DW + 1)) | (m_hd[i] << 1);
                    m_sb[i] = 1; m_bits[i] = DW + 2; m_div[i] = BC - 1; m_hv[i] = 0;
                end
            end
            if (m_ready != 0) begin
                if (dw) begin
                    m_hv[m_line] = 1; m_hd[m_line] = int'(host_wdata) & ((1 << DW) - 1);
                    m_last = m_line;
                end
                if (dw || ((ne >> m_line) & 1) == 0 || ns == 0) m_ready = 0;
            end else if (ns != 0) begin
                found = 0;
                for (int k = 1; k <= NL; k++) begin
                    idx = (m_last + k) % NL;
                    if (found == 0 && ((ne >> idx) & 1) != 0 && old_hv[idx] == 0) begin
                        found = 1; m_ready = 1; m_line = idx;
                    end
                end
            end
            m_en = ne; m_scan = ns; m_tie = nt;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        int exp_csr, exp_ser;
        cycles++;
        if (!rst && !done) begin
            exp_csr = (m_ready << 15) | (m_tie << 14) | (m_line << 8) | (m_scan << 5) | (m_busy << 4);
            exp_ser = 0;
            for (int i = 0; i < NL; i++)
                exp_ser |= ((m_sb[i] != 0) ? (m_sh[i] & 1) : 1) << i;
            chk("R3 status word", int'(csr_rdata), exp_csr);
            chk("R7 enable readback", int'(line_en_rdata), m_en);
            chk("R8 irq", int'(tx_irq), int'(m_ready != 0 && m_tie != 0));
            chk("R10 serial outputs", int'(ser_out), exp_ser);
        end
        if (cycles > WDOG && !done) begin
            failures++;
            checks++;
            $display("FAIL R1 watchdog actual=%0d cycles expected<%0d", cycles, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int a, input int d);
        host_we = 1'b1; host_addr = 2'(a); host_wdata = 16'(d);
        @(negedge clk);
        host_we = 1'b0; host_addr = 2'd0; host_wdata = 16'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!csr_rdata[15]) @(negedge clk);
    endtask

    initial begin
        int ln, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 status after reset", int'(csr_rdata), 0);
        chk("R1 enables after reset", int'(line_en_rdata), 0);
        chk("R1 irq after reset", int'(tx_irq), 0);
        chk("R1 idle outputs", int'(ser_out), 4'hF);

        // R2: enables on, scan off -> no ready
        wr(1, 16'hF);
        chk("R2 no ready without scan", int'(csr_rdata[15]), 0);
        idle(3);
        chk("R2 still no ready", int'(csr_rdata[15]), 0);

        // R3/R8: scan on, interrupt enable on
        wr(0, (1 << 14) | (1 << 5));
        chk("R3 ready on line 0", int'(csr_rdata), 16'hC020);
        chk("R8 irq with ready and enable", int'(tx_irq), 1);

        // R4/R5: eight back-to-back serves
        for (int k = 0; k < 8; k++) begin
            wait_ready();
            ln = int'(csr_rdata[9:8]);
            chk("R4 round-robin line order", ln, k % NL);
            wr(2, 16'h30 + k);
            chk("R5 ready drops on data write", int'(csr_rdata[15]), 0);
        end
        idle(2);
        chk("R6 all holding registers full", int'(csr_rdata[15]), 0);
        wr(2, 16'h77);  // R5: ignored while not ready
        chk("R5 write without ready ignored", int'(csr_rdata[15]), 0);

        // Drain every line
        idle(400);
        chk("R3 ready after drain", int'(csr_rdata[15]), 1);
        chk("R4 resumes after last served", int'(csr_rdata[9:8]), 0);

        // R7: withdraw enable of reported line 0
        wr(1, 16'hE);
        chk("R7 ready withdrawn", int'(csr_rdata[15]), 0);
        @(negedge clk);
        chk("R7 moved to next line ready", int'(csr_rdata[15]), 1);
        chk("R7 moved to line 1", int'(csr_rdata[9:8]), 1);

        // R8: interrupt enable gating
        wr(0, 1 << 5);
        chk("R8 irq low without enable", int'(tx_irq), 0);
        chk("R8 ready still set", int'(csr_rdata[15]), 1);
        wr(0, (1 << 14) | (1 << 5));
        chk("R8 irq back high", int'(tx_irq), 1);

        // R2: scan off withdraws ready
        wr(0, 0);
        chk("R2 scan off drops ready", int'(csr_rdata[15]), 0);

        // R9: clear sequence
        wr(0, 1 << 4);
        chk("R9 busy after clear", int'(csr_rdata[4]), 1);
        chk("R9 enables cleared", int'(line_en_rdata), 0);
        wr(1, 16'hF);
        chk("R9 busy second cycle", int'(csr_rdata[4]), 1);
        for (int j = 2; j < RC; j++) begin
            @(negedge clk);
            chk("R9 busy held", int'(csr_rdata[4]), 1);
        end
        @(negedge clk);
        chk("R9 busy released", int'(csr_rdata[4]), 0);
        chk("R9 write during clear ignored", int'(line_en_rdata), 0);

        // R10: frame on line 1
        wr(1, 16'h2);
        wr(0, 1 << 5);
        chk("R10 line 1 reported", int'(csr_rdata[9:8]), 1);
        wr(2, 16'hA5);
        n = 0;
        while (ser_out[1]) @(negedge clk);
        idle(BC / 2);
        for (int b = 0; b < DW + 2; b++) begin
            int expb;
            if (b == 0) expb = 0;
            else if (b == DW + 1) expb = 1;
            else expb = (8'hA5 >> (b - 1)) & 1;
            chk("R10 frame bit", int'(ser_out[1]), expb);
            idle(BC);
        end
        idle(20);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule